// File: doc/BRIEF.md
# Thinning Erosion Cell

This block decides whether the centre pixel of a 3x3 window of a one-bit image should be removed during one sub-iteration of a two-pass parallel thinning algorithm. Each cycle the caller can present a nine-bit window, a pass-select bit and a valid strobe. One clock later the block returns the new centre pixel value and a flag that shows whether the pixel was eroded. The block does not scan the image, buffer lines or count iterations. A surrounding engine handles those tasks and alternates the pass select between sub-iterations.

The window is numbered 0 to 8 in row-major order starting at the top-left, so bit 4 is the pixel under test. The eight surrounding pixels form a ring. The ring is read clockwise from the top-left corner: bits 0, 1, 2, 5, 8, 7, 6, 3. Three tests run on this ring in parallel:

- **Count test:** the number of foreground neighbours must lie within a bounded range.
- **Crossing test:** there must be exactly one background-to-foreground step around the closed ring.
- **Directional test:** a pass-dependent rule on the four edge neighbours (north = bit 1, east = bit 5, south = bit 7, west = bit 3).

The pass select is carried as a two-value enumerated type. `PASS_ONE` is encoded as 0 and `PASS_TWO` as 1, and a `unique case` statement picks the rule for the active pass.

Top module: `thin_erode_cell`

## Requirements
- R1: `out_valid` goes high exactly one clock after `win_valid` is sampled high and low one clock after `win_valid` is sampled low. Reset clears `out_valid`, `erode` and `pix_out` to 0.
- R2: A window whose centre bit `win[4]` is 0 never produces `erode` = 1, and it yields `pix_out` = 0.
- R3: Erosion requires a foreground neighbour count in the range CNT_LO..CNT_HI (defaults 2 and 6). A count of 0, 1, 7 or 8 blocks erosion.
- R4: Erosion requires exactly one 0-to-1 step when the ring (bits 0,1,2,5,8,7,6,3) is walked clockwise and closed back to bit 0. With zero steps or with two or more steps the pixel is kept.
- R5: With `pass_sel` = 0, the directional test passes when east (bit 5) is 0, or south (bit 7) is 0, or north (bit 1) and west (bit 3) are both 0.
- R6: With `pass_sel` = 1, the directional test passes when north (bit 1) is 0, or west (bit 3) is 0, or east (bit 5) and south (bit 7) are both 0.
- R7: `erode` is 1 only when the centre is 1 and all three tests pass together. `pix_out` equals the centre bit AND NOT `erode`.
- R8: While `win_valid` is 0, `erode` and `pix_out` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| win_valid | input | 1 | The window on `win` is valid this cycle |
| win | input | 9 | 3x3 window, bit i at row i/3, column i%3 |
| pass_sel | input | 1 | 0 selects the first pass rule, 1 the mirrored rule |
| out_valid | output | 1 | Result registers hold a new result |
| pix_out | output | 1 | New centre pixel value |
| erode | output | 1 | Centre pixel was removed |

## Verification
The bench builds the cell with its default count bounds of 2 and 6. It therefore reaches both edges of the count range: counts 1 and 7 fail, counts 2 and 6 pass. With a nine-bit window and one pass bit there are only 1024 input combinations, so the bench applies all of them and compares each result against its own model of the three tests. Directed windows for endpoints, lines, block edges and corners pin the mirrored pass rules to known answers.

// File: rtl/thin_pkg.sv
package thin_pkg;

    typedef enum logic {
        PASS_ONE = 1'b0,
        PASS_TWO = 1'b1
    } pass_e;

    localparam int WIN_BITS  = 9;
    localparam int RING_BITS = WIN_BITS - 1;

    // Reorder a row-major 3x3 window into the clockwise ring starting top-left.
    function automatic logic [RING_BITS-1:0] ring_of(input logic [WIN_BITS-1:0] w);
        logic [RING_BITS-1:0] r;
        r[0] = w[0];
        r[1] = w[1];
        r[2] = w[2];
        r[3] = w[5];
        r[4] = w[8];
        r[5] = w[7];
        r[6] = w[6];
        r[7] = w[3];
        return r;
    endfunction

endpackage

// File: rtl/thin_nbr_count.sv
module thin_nbr_count #(
    parameter int RING   = 8,
    parameter int CNT_LO = 2,
    parameter int CNT_HI = 6
) (
    input  logic [RING-1:0] ring,
    output logic            in_range
);
    localparam int CW = $clog2(RING + 1);

    logic [CW-1:0] total;

    always_comb begin
        total = '0;
        for (int i = 0; i < RING; i++) begin
            total = total + CW'(ring[i]);
        end
        in_range = (total >= CW'(CNT_LO)) && (total <= CW'(CNT_HI));
    end
endmodule

// File: rtl/thin_crossing.sv
module thin_crossing #(
    parameter int RING = 8
) (
    input  logic [RING-1:0] ring,
    output logic            single_region
);
    localparam int CW = $clog2(RING + 1);

    logic [RING-1:0] rise;
    logic [CW-1:0]   steps;

    for (genvar g = 0; g < RING; g++) begin : g_step
        assign rise[g] = !ring[g] && ring[(g + 1) % RING];
    end

    always_comb begin
        steps = '0;
        for (int i = 0; i < RING; i++) begin
            steps = steps + CW'(rise[i]);
        end
        single_region = (steps == CW'(1));
    end
endmodule

// File: rtl/thin_pass_rule.sv
module thin_pass_rule
    import thin_pkg::*;
(
    input  logic [RING_BITS-1:0] ring,
    input  pass_e                pass,
    output logic                 dir_ok
);
    logic north, east, south, west;

    assign north = ring[1];
    assign east  = ring[3];
    assign south = ring[5];
    assign west  = ring[7];

    always_comb begin
        unique case (pass)
            PASS_ONE: dir_ok = !east || !south || (!north && !west);
            PASS_TWO: dir_ok = !north || !west || (!east && !south);
            default:  dir_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/thin_erode_cell.sv
module thin_erode_cell
    import thin_pkg::*;
#(
    parameter int CNT_LO = 2,
    parameter int CNT_HI = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       win_valid,
    input  logic [8:0] win,
    input  logic       pass_sel,
    output logic       out_valid,
    output logic       pix_out,
    output logic       erode
);
    localparam int CTR = WIN_BITS / 2;

    logic [RING_BITS-1:0] ring;
    logic                 cnt_ok, cross_ok, dir_ok, kill;
    pass_e                pass;

    assign ring = ring_of(win);
    assign pass = pass_e'(pass_sel);

    thin_nbr_count #(
        .RING   (RING_BITS),
        .CNT_LO (CNT_LO),
        .CNT_HI (CNT_HI)
    ) u_count (
        .ring     (ring),
        .in_range (cnt_ok)
    );

    thin_crossing #(
        .RING (RING_BITS)
    ) u_cross (
        .ring          (ring),
        .single_region (cross_ok)
    );

    thin_pass_rule u_dir (
        .ring   (ring),
        .pass   (pass),
        .dir_ok (dir_ok)
    );

    assign kill = win[CTR] && cnt_ok && cross_ok && dir_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            erode     <= 1'b0;
            pix_out   <= 1'b0;
        end else begin
            out_valid <= win_valid;
            if (win_valid) begin
                erode   <= kill;
                pix_out <= win[CTR] && !kill;
            end
        end
    end
endmodule

// File: rtl/thin_erode_chk.sv
module thin_erode_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       win_valid,
    input logic [8:0] win,
    input logic       pass_sel,
    input logic       out_valid,
    input logic       pix_out,
    input logic       erode
);
    logic [3:0] nb_cnt;
    assign nb_cnt = 4'($countones(win & 9'h1EF));

    p_lat_hi_r1: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |=> out_valid);
    p_lat_lo_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid |=> !out_valid);
    p_bg_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && !win[4]) |=> (!erode && !pix_out));
    p_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && (nb_cnt < 4'd2 || nb_cnt > 4'd6)) |=> !erode);
    p_mix_r7: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |=> (pix_out == ($past(win[4]) && !erode)));
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid |=> ($stable(erode) && $stable(pix_out)));
    p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(erode && pix_out));
endmodule

bind thin_erode_cell thin_erode_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_valid (win_valid),
    .win       (win),
    .pass_sel  (pass_sel),
    .out_valid (out_valid),
    .pix_out   (pix_out),
    .erode     (erode)
);

// File: tb/thin_erode_cell_tb.sv
`timescale 1ns/1ps
module thin_erode_cell_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       win_valid = 1'b0;
    logic [8:0] win = '0;
    logic       pass_sel = 1'b0;
    logic       out_valid, pix_out, erode;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    thin_erode_cell dut_i (
        .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win(win),
        .pass_sel(pass_sel), .out_valid(out_valid), .pix_out(pix_out), .erode(erode)
    );

    // Model written from the requirements.
    function automatic bit model_erode(input logic [8:0] w, input logic p);
        logic [7:0] r;
        int cnt, steps;
        bit dir;
        r = {w[3], w[6], w[7], w[8], w[5], w[2], w[1], w[0]};
        cnt = 0; steps = 0;
        for (int i = 0; i < 8; i++) begin
            cnt += r[i];
            if (!r[i] && r[(i + 1) % 8]) steps++;
        end
        if (!p) dir = !w[5] || !w[7] || (!w[1] && !w[3]);
        else    dir = !w[1] || !w[3] || (!w[5] && !w[7]);
        return w[4] && cnt >= 2 && cnt <= 6 && steps == 1 && dir;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b (win=%b pass=%b)", req, act, exp, win, pass_sel);
        end
    endtask

    task automatic apply(input logic [8:0] w, input logic p);
        @(negedge clk);
        win = w; pass_sel = p; win_valid = 1'b1;
        @(negedge clk);
        win_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 reset out_valid", out_valid, 1'b0);
        check("R1 reset erode", erode, 1'b0);
        check("R1 reset pix_out", pix_out, 1'b0);
    endtask

    task automatic t_latency;
        apply(9'b110_110_000, 1'b0);
        check("R1 valid one clock later", out_valid, 1'b1);
        @(negedge clk);
        check("R1 valid drops", out_valid, 1'b0);
    endtask

    task automatic t_background;
        apply(9'b111_101_111, 1'b0);
        check("R2 bg erode", erode, 1'b0);
        check("R2 bg pix", pix_out, 1'b0);
        apply(9'b000_101_000, 1'b1);
        check("R2 bg erode p2", erode, 1'b0);
    endtask

    task automatic t_count;
        apply(9'b000_110_000, 1'b0);   // endpoint, one neighbour
        check("R3 endpoint kept", erode, 1'b0);
        check("R3 endpoint pix", pix_out, 1'b1);
        apply(9'h1FF, 1'b0);           // interior, eight neighbours
        check("R3 interior kept", erode, 1'b0);
        apply(9'b110_111_111, 1'b0);   // seven neighbours, SW missing
        check("R3 seven kept", erode, 1'b0);
    endtask

    task automatic t_crossing;
        apply(9'b000_111_000, 1'b0);   // line middle, two steps
        check("R4 line kept", erode, 1'b0);
        check("R4 line pix", pix_out, 1'b1);
        apply(9'b100_010_001, 1'b1);   // diagonal bridge
        check("R4 bridge kept", erode, 1'b0);
    endtask

    task automatic t_passes;
        apply(9'b110_110_000, 1'b0);   // lower-right corner
        check("R5 corner p1", erode, 1'b1);
        check("R7 corner pix", pix_out, 1'b0);
        apply(9'b000_111_111, 1'b0);   // bottom edge of region
        check("R5 south bg p1", erode, 1'b1);
        apply(9'b000_111_111, 1'b1);
        check("R6 south bg p2 kept", erode, 1'b0);
        apply(9'b111_111_000, 1'b0);   // top edge of region
        check("R5 north bg p1 kept", erode, 1'b0);
        apply(9'b111_111_000, 1'b1);
        check("R6 north bg p2", erode, 1'b1);
    endtask

    task automatic t_hold;
        apply(9'b110_110_000, 1'b0);
        @(negedge clk);
        win = 9'b000_010_000; pass_sel = 1'b1;
        @(negedge clk);
        check("R8 erode held", erode, 1'b1);
        check("R8 pix held", pix_out, 1'b0);
    endtask

    task automatic t_sweep;
        for (int k = 0; k < 1024; k++) begin
            logic e;
            apply(k[8:0], k[9]);
            e = model_erode(k[8:0], k[9]);
            check("R7 sweep erode", erode, e);
            check("R7 sweep pix", pix_out, k[4] && !e);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_latency();
        t_background();
        t_count();
        t_crossing();
        t_passes();
        t_hold();
        t_sweep();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule